// File: doc/BRIEF.md
# Sized Move Execution Unit

This unit carries out data moves for a small register-based datapath. A move can go from a register to a register, from an immediate to a register, from memory to a register (a load) or from a register to memory (a store). Every move has an operand size of 1, 2, 4 or 8 bytes. The unit holds a bank of 64-bit registers. Each register can be named through a 1-, 2-, 4- or 8-byte view, and each view covers the low-order bytes of that register.

Before any state changes, the unit checks that the operand size agrees with the view width of every register operand. For memory moves it forms the effective address from a sign-extended displacement, an optional base register and an optional index register scaled by 1, 2, 4 or 8. It then drives a byte-addressed memory port whose byte lanes are counted from the effective address. A move that breaks a rule gets a done pulse together with an illegal flag and has no other effect.

Top module: `movexec_unit`

## Requirements
- R1: An immediate is cut to the operand size before it is written. Writing 255 through a byte view gives 0xFF in bits 7:0, and writing 257 gives 0x01.
- R2: A write through the byte view (size code 0) or the word view (size code 1) changes only bits 7:0 or bits 15:0, and the rest of the register keeps its value.
- R3: A write through the 4-byte view (size code 2) stores bits 31:0 and clears bits 63:32. A write through the 8-byte view (size code 3) replaces all 64 bits.
- R4: A move is illegal if its size code differs from the view code of any register operand it uses: the source for kinds 0 and 3, the destination for kinds 0, 1 and 2. An illegal move changes no register and issues no memory request. Kind codes are 0 register-to-register, 1 immediate, 2 load and 3 store.
- R5: A register-to-register move copies the low size bytes of the source into the destination view, following R2 and R3.
- R6: The effective address is the sign-extended displacement, plus the base register when it is enabled, plus the index register times the scale when the index is enabled. The sum wraps modulo 2^64 and raises no flag.
- R7: For a load or a store, a scale value other than 1, 2, 4 or 8 makes the move illegal, and no memory request is issued.
- R8: A legal store drives mem_req with mem_we high for one cycle, in the cycle after it is accepted. In that cycle mem_addr is the effective address, mem_be has its low N bits set for an N-byte size, byte lane i of mem_wdata holds byte i of the source view, and done is high.
- R9: A legal load drives mem_req with mem_we low in the cycle after it is accepted and holds op_ready low until mem_rvalid arrives. The destination view is written, and done pulses, in the cycle after mem_rvalid. Lanes of mem_rdata above the operand size are ignored.
- R10: Every accepted move other than a legal load pulses done for one cycle in the cycle after acceptance. illegal is only ever high together with done.
- R11: After reset every register reads zero, op_ready is high, and mem_req, done and illegal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A move is presented |
| op_ready | output | 1 | Unit can accept a move |
| op_kind | input | 2 | 0 reg-reg, 1 immediate, 2 load, 3 store |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 long, 3 quad |
| src_reg | input | 4 | Source register number |
| src_view | input | 2 | View width code of the source register |
| dst_reg | input | 4 | Destination register number |
| dst_view | input | 2 | View width code of the destination register |
| imm | input | 64 | Immediate value |
| disp | input | 32 | Signed displacement |
| base_en | input | 1 | Base register is used |
| base_reg | input | 4 | Base register number |
| idx_en | input | 1 | Index register is used |
| idx_reg | input | 4 | Index register number |
| scale | input | 4 | Index scale as an integer value |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of lane 0 |
| mem_be | output | 8 | Byte enables, lane i covers mem_addr+i |
| mem_wdata | output | 64 | Store data, little-endian lanes |
| mem_rvalid | input | 1 | Load response valid |
| mem_rdata | input | 64 | Load response data, little-endian lanes |
| done | output | 1 | Move completed |
| illegal | output | 1 | Move rejected |

## Verification
Some handshake rules are checked on every cycle. illegal never appears without done. Every byte-enable pattern is a contiguous run starting at lane 0. A store request always coincides with its done pulse. A pending load finishes in the cycle after its response. A bad scale on a memory move is always rejected, and any accepted non-load move finishes in the next cycle. The other behaviours need directed scenarios that read registers back through stores: the data results of view aliasing, truncation, zero-extension, register copies, effective-address arithmetic with negative displacements and wrap-around, and the fact that a rejected move leaves every register untouched.

// File: rtl/mvx_pkg.sv
package mvx_pkg;

    localparam int XLEN   = 64;
    localparam int XBYTES = XLEN / 8;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_L = 2'd2,
        SZ_Q = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        K_RR    = 2'd0,
        K_IMM   = 2'd1,
        K_LOAD  = 2'd2,
        K_STORE = 2'd3
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [XLEN-1:0]   addr;
        logic [XBYTES-1:0] be;
        logic [XLEN-1:0]   wdata;
    } mreq_t;

    typedef struct packed {
        logic            en;
        logic [3:0]      idx;
        size_e           size;
        logic [XLEN-1:0] data;
    } wport_t;

    function automatic logic [XLEN-1:0] size_mask(size_e s);
        case (s)
            SZ_B:    return 64'h0000_0000_0000_00FF;
            SZ_W:    return 64'h0000_0000_0000_FFFF;
            SZ_L:    return 64'h0000_0000_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    function automatic logic [XBYTES-1:0] size_be(size_e s);
        case (s)
            SZ_B:    return 8'h01;
            SZ_W:    return 8'h03;
            SZ_L:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] merge_view(logic [XLEN-1:0] old_v,
                                                   logic [XLEN-1:0] new_v,
                                                   size_e s);
        case (s)
            SZ_B:    return {old_v[63:8],  new_v[7:0]};
            SZ_W:    return {old_v[63:16], new_v[15:0]};
            SZ_L:    return {32'h0, new_v[31:0]};
            default: return new_v;
        endcase
    endfunction

endpackage

// File: rtl/mvx_regfile.sv
module mvx_regfile
    import mvx_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int RIDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  size_e             wr_size,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [RIDX_W-1:0] rb_idx,
    input  logic [RIDX_W-1:0] rc_idx,
    output logic [XLEN-1:0]   ra_data,
    output logic [XLEN-1:0]   rb_data,
    output logic [XLEN-1:0]   rc_data
);

    logic [XLEN-1:0] rows [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_row
        logic [XLEN-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_idx == RIDX_W'(g))) begin
                q <= merge_view(q, wr_data, wr_size);
            end
        end
        assign rows[g] = q;
    end

    assign ra_data = rows[ra_idx];
    assign rb_data = rows[rb_idx];
    assign rc_data = rows[rc_idx];

endmodule

// File: rtl/mvx_agen.sv
module mvx_agen
    import mvx_pkg::*;
#(
    parameter int DISP_W = 32
) (
    input  logic [DISP_W-1:0] disp,
    input  logic              base_en,
    input  logic [XLEN-1:0]   base_val,
    input  logic              idx_en,
    input  logic [XLEN-1:0]   idx_val,
    input  logic [3:0]        scale,
    output logic [XLEN-1:0]   ea,
    output logic              scale_ok
);

    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] disp_x;
    logic [XLEN-1:0] base_t;
    logic [XLEN-1:0] idx_t;
    logic [1:0]      shamt;

    assign disp_x = {{EXT_W{disp[DISP_W-1]}}, disp};

    always_comb begin
        scale_ok = 1'b1;
        shamt    = 2'd0;
        case (scale)
            4'd1:    shamt = 2'd0;
            4'd2:    shamt = 2'd1;
            4'd4:    shamt = 2'd2;
            4'd8:    shamt = 2'd3;
            default: scale_ok = 1'b0;
        endcase
    end

    assign base_t = base_en ? base_val : '0;
    assign idx_t  = idx_en ? (idx_val << shamt) : '0;
    assign ea     = disp_x + base_t + idx_t;

endmodule

// File: rtl/mvx_legal.sv
module mvx_legal
    import mvx_pkg::*;
(
    input  kind_e kind,
    input  size_e size,
    input  size_e src_view,
    input  size_e dst_view,
    input  logic  scale_ok,
    output logic  bad
);

    logic src_mis;
    logic dst_mis;

    assign src_mis = (src_view != size);
    assign dst_mis = (dst_view != size);

    always_comb begin
        case (kind)
            K_RR:    bad = src_mis || dst_mis;
            K_IMM:   bad = dst_mis;
            K_LOAD:  bad = dst_mis || !scale_ok;
            default: bad = src_mis || !scale_ok;
        endcase
    end

endmodule

// File: rtl/movexec_unit.sv
module movexec_unit
    import mvx_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int DISP_W = 32,
    localparam int RIDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        op_size,
    input  logic [RIDX_W-1:0] src_reg,
    input  logic [1:0]        src_view,
    input  logic [RIDX_W-1:0] dst_reg,
    input  logic [1:0]        dst_view,
    input  logic [63:0]       imm,
    input  logic [DISP_W-1:0] disp,
    input  logic              base_en,
    input  logic [RIDX_W-1:0] base_reg,
    input  logic              idx_en,
    input  logic [RIDX_W-1:0] idx_reg,
    input  logic [3:0]        scale,
    output logic              mem_req,
    output logic              mem_we,
    output logic [63:0]       mem_addr,
    output logic [7:0]        mem_be,
    output logic [63:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic              illegal
);

    kind_e  kind;
    size_e  size;
    state_e state_q;
    mreq_t  mreq_q;
    wport_t wp;

    logic              accept;
    logic              bad;
    logic              scale_ok;
    logic              ld_fin;
    logic [XLEN-1:0]   src_val;
    logic [XLEN-1:0]   base_val;
    logic [XLEN-1:0]   idx_val;
    logic [XLEN-1:0]   ea;
    logic [RIDX_W-1:0] ld_dst_q;
    size_e             ld_size_q;
    logic              done_q;
    logic              ill_q;

    assign kind     = kind_e'(op_kind);
    assign size     = size_e'(op_size);
    assign op_ready = (state_q == ST_IDLE);
    assign accept   = op_valid && op_ready;
    assign ld_fin   = (state_q == ST_WAIT) && mem_rvalid;

    mvx_regfile #(.NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wp.en),
        .wr_idx  (wp.idx[RIDX_W-1:0]),
        .wr_size (wp.size),
        .wr_data (wp.data),
        .ra_idx  (src_reg),
        .rb_idx  (base_reg),
        .rc_idx  (idx_reg),
        .ra_data (src_val),
        .rb_data (base_val),
        .rc_data (idx_val)
    );

    mvx_agen #(.DISP_W(DISP_W)) u_agen (
        .disp     (disp),
        .base_en  (base_en),
        .base_val (base_val),
        .idx_en   (idx_en),
        .idx_val  (idx_val),
        .scale    (scale),
        .ea       (ea),
        .scale_ok (scale_ok)
    );

    mvx_legal u_legal (
        .kind     (kind),
        .size     (size),
        .src_view (size_e'(src_view)),
        .dst_view (size_e'(dst_view)),
        .scale_ok (scale_ok),
        .bad      (bad)
    );

    // Single register write port: a returning load has priority because no
    // new move can be accepted while one is outstanding.
    always_comb begin
        wp      = '0;
        wp.size = size;
        if (ld_fin) begin
            wp.en   = 1'b1;
            wp.idx  = 4'(ld_dst_q);
            wp.size = ld_size_q;
            wp.data = mem_rdata & size_mask(ld_size_q);
        end else if (accept && !bad && (kind == K_RR)) begin
            wp.en   = 1'b1;
            wp.idx  = 4'(dst_reg);
            wp.data = src_val & size_mask(size);
        end else if (accept && !bad && (kind == K_IMM)) begin
            wp.en   = 1'b1;
            wp.idx  = 4'(dst_reg);
            wp.data = imm & size_mask(size);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            mreq_q    <= '0;
            done_q    <= 1'b0;
            ill_q     <= 1'b0;
            ld_dst_q  <= '0;
            ld_size_q <= SZ_B;
        end else begin
            done_q     <= 1'b0;
            ill_q      <= 1'b0;
            mreq_q.req <= 1'b0;
            if (accept) begin
                if (bad) begin
                    done_q <= 1'b1;
                    ill_q  <= 1'b1;
                end else begin
                    case (kind)
                        K_STORE: begin
                            mreq_q <= '{req: 1'b1, we: 1'b1, addr: ea,
                                        be: size_be(size),
                                        wdata: src_val & size_mask(size)};
                            done_q <= 1'b1;
                        end
                        K_LOAD: begin
                            mreq_q    <= '{req: 1'b1, we: 1'b0, addr: ea,
                                           be: size_be(size), wdata: '0};
                            ld_dst_q  <= dst_reg;
                            ld_size_q <= size;
                            state_q   <= ST_WAIT;
                        end
                        default: done_q <= 1'b1;
                    endcase
                end
            end
            if (ld_fin) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
            end
        end
    end

    assign mem_req   = mreq_q.req;
    assign mem_we    = mreq_q.we;
    assign mem_addr  = mreq_q.addr;
    assign mem_be    = mreq_q.be;
    assign mem_wdata = mreq_q.wdata;
    assign done      = done_q;
    assign illegal   = ill_q;

endmodule

// File: rtl/mvx_sva.sv
module mvx_sva (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic       op_ready,
    input logic [1:0] op_kind,
    input logic [3:0] scale,
    input logic       mem_req,
    input logic       mem_we,
    input logic [7:0] mem_be,
    input logic       mem_rvalid,
    input logic       done,
    input logic       illegal
);

    logic scale_bad;
    assign scale_bad = (scale != 4'd1) && (scale != 4'd2) &&
                       (scale != 4'd4) && (scale != 4'd8);

    AST_ILLEGAL_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> done); // R10

    AST_ILLEGAL_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !mem_req); // R4

    AST_BE_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_be == 8'h01 || mem_be == 8'h03 ||
                     mem_be == 8'h0F || mem_be == 8'hFF)); // R8

    AST_STORE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> done); // R8

    AST_LOAD_FINISH: assert property (@(posedge clk) disable iff (rst)
        (mem_rvalid && !op_ready) |=> (done && op_ready)); // R9

    AST_BAD_SCALE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_kind[1] && scale_bad) |=> (illegal && !mem_req)); // R7

    AST_NONLOAD_DONE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_kind != 2'd2) |=> done); // R10

endmodule

bind movexec_unit mvx_sva u_mvx_sva (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .op_kind    (op_kind),
    .scale      (scale),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .mem_rvalid (mem_rvalid),
    .done       (done),
    .illegal    (illegal)
);

// File: tb/tb_movexec_unit.sv
module tb_movexec_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic        op_ready;
    logic [1:0]  op_kind;
    logic [1:0]  op_size;
    logic [3:0]  src_reg;
    logic [1:0]  src_view;
    logic [3:0]  dst_reg;
    logic [1:0]  dst_view;
    logic [63:0] imm;
    logic [31:0] disp;
    logic        base_en;
    logic [3:0]  base_reg;
    logic        idx_en;
    logic [3:0]  idx_reg;
    logic [3:0]  scale;
    logic        mem_req;
    logic        mem_we;
    logic [63:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        done;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    movexec_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_kind(op_kind), .op_size(op_size), .src_reg(src_reg),
        .src_view(src_view), .dst_reg(dst_reg), .dst_view(dst_view),
        .imm(imm), .disp(disp), .base_en(base_en), .base_reg(base_reg),
        .idx_en(idx_en), .idx_reg(idx_reg), .scale(scale),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one move at a negedge; return at the negedge after acceptance.
    task automatic issue(input logic [1:0] k, input logic [1:0] s,
                         input int src, input logic [1:0] sv,
                         input int dst, input logic [1:0] dv,
                         input logic [63:0] im, input logic [31:0] d,
                         input logic ben, input int br,
                         input logic xen, input int xr, input logic [3:0] sc);
        op_kind = k; op_size = s; src_reg = 4'(src); src_view = sv;
        dst_reg = 4'(dst); dst_view = dv; imm = im; disp = d;
        base_en = ben; base_reg = 4'(br); idx_en = xen; idx_reg = 4'(xr);
        scale = sc; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic set_imm(input logic [1:0] s, input int r, input logic [63:0] v);
        issue(2'd1, s, 0, s, r, s, v, 32'd0, 1'b0, 0, 1'b0, 0, 4'd1);
    endtask

    // Read a register back by storing its quad view to address 0x40.
    task automatic rd(input int r, output logic [63:0] v);
        issue(2'd3, 2'd3, r, 2'd3, 0, 2'd3, 64'd0, 32'h40, 1'b0, 0, 1'b0, 0, 4'd1);
        v = mem_wdata;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        chk("R11 op_ready", 64'(op_ready), 64'd1);
        chk("R11 mem_req", 64'(mem_req), 64'd0);
        chk("R11 done", 64'(done), 64'd0);
        chk("R11 illegal", 64'(illegal), 64'd0);
        rd(7, v);
        chk("R11 reg7 zero", v, 64'd0);
    endtask

    task automatic t_truncate();
        logic [63:0] v;
        set_imm(2'd0, 1, 64'd255);
        chk("R10 done imm", 64'(done), 64'd1);
        rd(1, v);
        chk("R1 byte 255", v, 64'h0000_0000_0000_00FF);
        set_imm(2'd0, 1, 64'd257);
        rd(1, v);
        chk("R1 byte 257", v, 64'h0000_0000_0000_0001);
    endtask

    task automatic t_partial();
        logic [63:0] v;
        set_imm(2'd3, 2, 64'h1122_3344_5566_7788);
        set_imm(2'd0, 2, 64'hFFFF_FFFF_FFFF_FFAA);
        rd(2, v);
        chk("R2 byte keeps upper", v, 64'h1122_3344_5566_77AA);
        set_imm(2'd1, 2, 64'h0000_0000_1234_BEEF);
        rd(2, v);
        chk("R2 word keeps upper", v, 64'h1122_3344_5566_BEEF);
    endtask

    task automatic t_long();
        logic [63:0] v;
        set_imm(2'd3, 2, 64'hFFFF_FFFF_FFFF_FFFF);
        set_imm(2'd2, 2, 64'h7777_7777_DEAD_BEEF);
        rd(2, v);
        chk("R3 long zero-extends", v, 64'h0000_0000_DEAD_BEEF);
        set_imm(2'd3, 2, 64'hCAFE_F00D_0BAD_CAB1);
        rd(2, v);
        chk("R3 quad full", v, 64'hCAFE_F00D_0BAD_CAB1);
    endtask

    task automatic t_mismatch();
        logic [63:0] v;
        set_imm(2'd3, 5, 64'h0123_4567_89AB_CDEF);
        set_imm(2'd3, 6, 64'h5A5A_5A5A_5A5A_5A5A);
        issue(2'd0, 2'd3, 5, 2'd2, 6, 2'd3, 64'd0, 32'd0, 1'b0, 0, 1'b0, 0, 4'd1);
        chk("R4 quad from long view illegal", 64'(illegal), 64'd1);
        chk("R10 done with illegal", 64'(done), 64'd1);
        issue(2'd0, 2'd2, 5, 2'd2, 6, 2'd3, 64'd0, 32'd0, 1'b0, 0, 1'b0, 0, 4'd1);
        chk("R4 long into quad view illegal", 64'(illegal), 64'd1);
        issue(2'd1, 2'd3, 0, 2'd3, 6, 2'd2, 64'h1, 32'd0, 1'b0, 0, 1'b0, 0, 4'd1);
        chk("R4 imm quad into long view illegal", 64'(illegal), 64'd1);
        issue(2'd3, 2'd3, 5, 2'd2, 0, 2'd3, 64'd0, 32'h40, 1'b0, 0, 1'b0, 0, 4'd1);
        chk("R4 store mismatch illegal", 64'(illegal), 64'd1);
        chk("R4 store mismatch no mem_req", 64'(mem_req), 64'd0);
        rd(6, v);
        chk("R4 dest unchanged", v, 64'h5A5A_5A5A_5A5A_5A5A);
    endtask

    task automatic t_regreg();
        logic [63:0] v;
        set_imm(2'd3, 3, 64'hAAAA_BBBB_CCCC_1357);
        set_imm(2'd3, 4, 64'h9999_8888_7777_6666);
        issue(2'd0, 2'd1, 3, 2'd1, 4, 2'd1, 64'd0, 32'd0, 1'b0, 0, 1'b0, 0, 4'd1);
        chk("R5 rr legal", 64'(illegal), 64'd0);
        rd(4, v);
        chk("R5 word copy", v, 64'h9999_8888_7777_1357);
        issue(2'd0, 2'd2, 3, 2'd2, 4, 2'd2, 64'd0, 32'd0, 1'b0, 0, 1'b0, 0, 4'd1);
        rd(4, v);
        chk("R5 long copy zero-ext", v, 64'h0000_0000_CCCC_1357);
    endtask

    task automatic t_agen();
        set_imm(2'd3, 11, 64'h0000_0000_0000_00A2);
        set_imm(2'd3, 0, 64'd4);
        set_imm(2'd3, 12, 64'h5555_6666_7777_1234);
        issue(2'd3, 2'd1, 12, 2'd1, 0, 2'd1, 64'd0, -32'sd3, 1'b1, 11, 1'b1, 0, 4'd1);
        chk("R6 addr -3+base+idx", mem_addr, 64'h0000_0000_0000_00A3);
        chk("R8 word be", 64'(mem_be), 64'h03);
        chk("R8 word wdata", mem_wdata, 64'h1234);
        set_imm(2'd3, 11, 64'h0000_0000_0000_00A0);
        set_imm(2'd3, 0, 64'd2);
        issue(2'd3, 2'd2, 12, 2'd2, 0, 2'd2, 64'd0, -32'sd5, 1'b1, 11, 1'b1, 0, 4'd4);
        chk("R6 addr scale4 -5", mem_addr, 64'h0000_0000_0000_00A3);
        chk("R8 long be", 64'(mem_be), 64'h0F);
        set_imm(2'd3, 0, 64'd3);
        issue(2'd3, 2'd0, 12, 2'd0, 0, 2'd0, 64'd0, 32'h10, 1'b0, 0, 1'b1, 0, 4'd8);
        chk("R6 index only scale8", mem_addr, 64'h28);
        chk("R8 byte wdata", mem_wdata, 64'h34);
        set_imm(2'd3, 11, 64'hFFFF_FFFF_FFFF_FFFE);
        issue(2'd3, 2'd3, 12, 2'd3, 0, 2'd3, 64'd0, 32'd4, 1'b1, 11, 1'b0, 0, 4'd1);
        chk("R6 wrap", mem_addr, 64'd2);
        chk("R6 wrap no flag", 64'(illegal), 64'd0);
    endtask

    task automatic t_bad_scale();
        issue(2'd3, 2'd3, 12, 2'd3, 0, 2'd3, 64'd0, 32'd0, 1'b1, 11, 1'b1, 0, 4'd3);
        chk("R7 store scale3 illegal", 64'(illegal), 64'd1);
        chk("R7 store scale3 no req", 64'(mem_req), 64'd0);
        issue(2'd2, 2'd3, 0, 2'd3, 9, 2'd3, 64'd0, 32'd0, 1'b1, 11, 1'b0, 0, 4'd0);
        chk("R7 load scale0 illegal", 64'(illegal), 64'd1);
        chk("R7 load scale0 no req", 64'(mem_req), 64'd0);
        chk("R7 ready stays", 64'(op_ready), 64'd1);
    endtask

    task automatic t_store_base();
        set_imm(2'd3, 8, 64'h0000_0000_0000_1000);
        set_imm(2'd3, 9, 64'h8765_4321_0FED_CBA9);
        issue(2'd3, 2'd2, 9, 2'd2, 0, 2'd2, 64'd0, 32'd0, 1'b1, 8, 1'b0, 0, 4'd1);
        chk("R8 req", 64'(mem_req), 64'd1);
        chk("R8 we", 64'(mem_we), 64'd1);
        chk("R8 addr=base", mem_addr, 64'h1000);
        chk("R8 be 4 bytes", 64'(mem_be), 64'h0F);
        chk("R8 wdata low4", mem_wdata, 64'h0FED_CBA9);
        chk("R8 done with store", 64'(done), 64'd1);
        @(negedge clk);
        chk("R8 req one cycle", 64'(mem_req), 64'd0);
    endtask

    task automatic do_load(input logic [1:0] s, input int dst, input int lat,
                           input logic [63:0] rdata, input string tag);
        issue(2'd2, s, 0, s, dst, s, 64'd0, 32'h80, 1'b0, 0, 1'b0, 0, 4'd1);
        chk({tag, " R9 req"}, 64'(mem_req), 64'd1);
        chk({tag, " R9 read"}, 64'(mem_we), 64'd0);
        chk({tag, " R9 addr"}, mem_addr, 64'h80);
        chk({tag, " R9 not ready"}, 64'(op_ready), 64'd0);
        chk({tag, " R9 no early done"}, 64'(done), 64'd0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk({tag, " R9 waiting"}, 64'(done), 64'd0);
        end
        mem_rvalid = 1'b1;
        mem_rdata  = rdata;
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        chk({tag, " R9 done after rvalid"}, 64'(done), 64'd1);
        chk({tag, " R9 ready again"}, 64'(op_ready), 64'd1);
    endtask

    task automatic t_load();
        logic [63:0] v;
        set_imm(2'd3, 10, 64'h1111_1111_1111_1111);
        do_load(2'd0, 10, 0, 64'hFFFF_FFFF_FFFF_FF5A, "byte");
        rd(10, v);
        chk("R9 byte load masks upper lanes", v, 64'h1111_1111_1111_115A);
        do_load(2'd3, 10, 3, 64'h0102_0304_0506_0708, "quad");
        rd(10, v);
        chk("R9 quad load", v, 64'h0102_0304_0506_0708);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_kind = '0; op_size = '0;
        src_reg = '0; src_view = '0; dst_reg = '0; dst_view = '0;
        imm = '0; disp = '0; base_en = 1'b0; base_reg = '0;
        idx_en = 1'b0; idx_reg = '0; scale = 4'd1;
        mem_rvalid = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_truncate();
        t_partial();
        t_long();
        t_mismatch();
        t_regreg();
        t_agen();
        t_bad_scale();
        t_store_base();
        t_load();
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule